// File: doc/BRIEF.md
# Serial Output Model of a Successive-Approximation Converter

This block stands in for a converter's digital pins so that host readout logic can be exercised without an analog model. The host drives an active-low chip select and a serial clock. The block also receives a signed sample on a parallel input, and that input may be wider than the output word. The block answers on a serial data line that has an explicit output-enable. When the enable is low, the line is treated as released.

The falling edge of chip select starts a frame. At that edge the block clamps the sample into the output word range and holds the result. The block keeps the data line disabled for a fixed lead-in count of falling serial-clock edges. It enables the line with a zero bit, then shifts the held word out most significant bit first, one bit per falling edge. After the last bit it drives zero until chip select goes high again.

The block does not clock on the serial clock. It oversamples chip select and the serial clock with its own system clock, synchronises both and detects their edges. As a result, each pin event reaches the outputs a fixed number of system clocks later.

Top module: `sar_sdo_emulator`

## Requirements
- R1: While chip select is high, `sdo_oe` is 0 and `sdo` is 0, whatever the serial clock does.
- R2: The word sent in a frame is the sample present when the chip-select fall is detected (SYNC_STAGES+1 system clocks after the pin falls). Later changes of `sample_in` do not alter that frame.
- R3: After chip select falls, `sdo_oe` stays 0 through the first LEAD_EDGES-1 falling serial-clock edges. On falling edge number LEAD_EDGES it becomes 1 with `sdo` = 0.
- R4: Falling edges LEAD_EDGES+1 through LEAD_EDGES+DATA_W present the held word on `sdo`, bit DATA_W-1 first and bit 0 last, in two's complement. Rising serial-clock edges change neither output.
- R5: From falling edge LEAD_EDGES+DATA_W+1 onward, `sdo` is 0 with `sdo_oe` = 1 for any number of further edges. The edge count saturates and never restarts the sequence.
- R6: A sample above 2^(DATA_W-1)-1 is sent as 0 followed by DATA_W-1 ones.
- R7: A sample below -2^(DATA_W-1) is sent as 1 followed by DATA_W-1 zeros.
- R8: A chip-select rise in mid-frame disables the output. The next frame starts again from the full lead-in.
- R9: After reset, `sdo_oe` and `sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sample_in | input | IN_W | Signed sample to be sent in the next frame |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Data line enable; 0 means released |

## Verification
The bench builds the block with DATA_W = 8, IN_W = 9, LEAD_EDGES = 5 and SYNC_STAGES = 2. This configuration makes the entire input space reachable: all 512 input values are framed and read back bit by bit. The sweep therefore covers every in-range code and every positive and negative overrange value. The bench compares each bit against a clamp computed in the bench. Alternate frames add extra clock edges to exercise the saturating count. The bench also aborts a frame partway through the data and toggles the serial clock while deselected.

// File: rtl/sdo_emu_pkg.sv
package sdo_emu_pkg;

    // Frame phase of the serial sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_DATA = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;

endpackage

// File: rtl/sdo_edge_sync.sv
module sdo_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall
);

    // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {(STAGES+1){RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign fall  = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/sdo_sat_clip.sv
module sdo_sat_clip #(
    parameter int IN_W   = 18,
    parameter int DATA_W = 16
) (
    input  logic signed [IN_W-1:0]   din,
    output logic        [DATA_W-1:0] dout
);

    generate
        if (IN_W > DATA_W) begin : g_clamp
            localparam logic signed [IN_W-1:0] POS_LIM = IN_W'((1 << (DATA_W-1)) - 1);
            localparam logic signed [IN_W-1:0] NEG_LIM = IN_W'(-(1 << (DATA_W-1)));
            always_comb begin
                if (din > POS_LIM)      dout = {1'b0, {(DATA_W-1){1'b1}}};
                else if (din < NEG_LIM) dout = {1'b1, {(DATA_W-1){1'b0}}};
                else                    dout = din[DATA_W-1:0];
            end
        end else begin : g_pass
            // Narrower or equal input: sign extension cannot overflow
            assign dout = DATA_W'(din);
        end
    endgenerate

endmodule

// File: rtl/sdo_frame_seq.sv
module sdo_frame_seq
    import sdo_emu_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int LEAD_EDGES = 5     // must be at least 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_high,
    input  logic              sclk_fall,
    input  logic [DATA_W-1:0] word_in,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int LAST_EDGE = LEAD_EDGES + DATA_W;
    localparam int CNT_MAX   = LAST_EDGE + 1;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LEAD_C = CNT_W'(LEAD_EDGES);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST_EDGE);
    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(CNT_MAX);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  shreg;
        logic               dout;
        logic               oe;
    } seq_st_t;

    localparam seq_st_t SEQ_RST = '{ph: PH_IDLE, cnt: '0, shreg: '0, dout: 1'b0, oe: 1'b0};

    seq_st_t          st_d, st_q;
    logic [CNT_W-1:0] nxt_cnt;

    always_comb begin
        st_d    = st_q;
        nxt_cnt = (st_q.cnt == MAX_C) ? st_q.cnt : st_q.cnt + 1'b1;
        if (cs_fall) begin
            st_d.ph    = PH_LEAD;
            st_d.cnt   = '0;
            st_d.shreg = word_in;
            st_d.dout  = 1'b0;
            st_d.oe    = 1'b0;
        end else if (cs_high) begin
            st_d = SEQ_RST;
        end else if (sclk_fall && (st_q.ph != PH_IDLE)) begin
            st_d.cnt = nxt_cnt;
            unique case (st_q.ph)
                PH_LEAD: begin
                    if (nxt_cnt == LEAD_C) begin
                        st_d.oe   = 1'b1;
                        st_d.dout = 1'b0;
                        st_d.ph   = PH_DATA;
                    end
                end
                PH_DATA: begin
                    st_d.dout  = st_q.shreg[DATA_W-1];
                    st_d.shreg = {st_q.shreg[DATA_W-2:0], 1'b0};
                    if (nxt_cnt == LAST_C) st_d.ph = PH_TAIL;
                end
                PH_TAIL: begin
                    st_d.dout = 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_RST;
        else        st_q <= st_d;
    end

    assign sdo    = st_q.dout;
    assign sdo_oe = st_q.oe;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE) |-> (!st_q.oe && !st_q.dout)); // R1
    AST_ENABLE_AT_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oe) |-> ((st_q.cnt == LEAD_C) && !st_q.dout)); // R3
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= MAX_C); // R5
    AST_CNT_HOLDS_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cnt == MAX_C) && !cs_fall && !cs_high) |=> (st_q.cnt == MAX_C)); // R5
    AST_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt > LAST_C) |-> (!st_q.dout && st_q.oe)); // R5

endmodule

// File: rtl/sar_sdo_emulator.sv
module sar_sdo_emulator #(
    parameter int DATA_W      = 16,
    parameter int IN_W        = 18,
    parameter int LEAD_EDGES  = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   sclk,
    input  logic signed [IN_W-1:0] sample_in,
    output logic                   sdo,
    output logic                   sdo_oe
);

    localparam int N_PINS = 2;   // index 0: chip select, index 1: serial clock

    logic [N_PINS-1:0] pin_raw, pin_lvl, pin_fall;
    logic [DATA_W-1:0] word;

    assign pin_raw = {sclk, cs_n};

    generate
        for (genvar g = 0; g < N_PINS; g++) begin : g_sync
            sdo_edge_sync #(
                .STAGES  (SYNC_STAGES),
                .RST_VAL (1'b1)
            ) i_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (pin_raw[g]),
                .level (pin_lvl[g]),
                .fall  (pin_fall[g])
            );
        end
    endgenerate

    sdo_sat_clip #(
        .IN_W   (IN_W),
        .DATA_W (DATA_W)
    ) i_clip (
        .din  (sample_in),
        .dout (word)
    );

    sdo_frame_seq #(
        .DATA_W     (DATA_W),
        .LEAD_EDGES (LEAD_EDGES)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_fall   (pin_fall[0]),
        .cs_high   (pin_lvl[0]),
        .sclk_fall (pin_fall[1]),
        .word_in   (word),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    AST_CS_RISE_DROPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_lvl[0]) |=> !sdo_oe); // R8
    AST_SCLK_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_lvl[1] && !pin_lvl[0]) |=> ($stable(sdo) && $stable(sdo_oe))); // R4

    generate
        if (IN_W > DATA_W) begin : g_sat_chk
            localparam logic signed [IN_W-1:0] POS_LIM = IN_W'((1 << (DATA_W-1)) - 1);
            localparam logic signed [IN_W-1:0] NEG_LIM = IN_W'(-(1 << (DATA_W-1)));
            AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                (sample_in > POS_LIM) |-> (word == {1'b0, {(DATA_W-1){1'b1}}})); // R6
            AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                (sample_in < NEG_LIM) |-> (word == {1'b1, {(DATA_W-1){1'b0}}})); // R7
        end
    endgenerate

endmodule

// File: tb/test_sar_sdo_emulator.sv
module test_sar_sdo_emulator;

    localparam int DW   = 8;
    localparam int IW   = 9;
    localparam int LEAD = 5;
    localparam int FULL = LEAD + DW + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cs_n = 1'b1;
    logic                 sclk = 1'b1;
    logic signed [IW-1:0] sample_in = '0;
    logic                 sdo, sdo_oe;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    sar_sdo_emulator #(
        .DATA_W      (DW),
        .IN_W        (IW),
        .LEAD_EDGES  (LEAD),
        .SYNC_STAGES (2)
    ) i_sar_sdo_emulator (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sample_in (sample_in),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic exp_oe, input logic exp_sdo);
        total++;
        if (sdo_oe !== exp_oe || sdo !== exp_sdo) begin
            bad++;
            $display("FAIL %s: oe=%b sdo=%b expected oe=%b sdo=%b", req, sdo_oe, sdo, exp_oe, exp_sdo);
        end
    endtask

    function automatic int clampv(input int v);
        if (v > (1 << (DW-1)) - 1) return (1 << (DW-1)) - 1;
        if (v < -(1 << (DW-1)))    return -(1 << (DW-1));
        return v;
    endfunction

    // Runs n_edges falling clock edges of a frame, then raises chip select
    task automatic run_frame(input int v, input int n_edges, input string dtag, input string endtag);
        int u;
        logic eo, es;
        string tg;
        u = clampv(v) & ((1 << DW) - 1);
        sample_in = IW'(v);
        cs_n = 1'b0;
        tick(3);
        sample_in = ~IW'(v);   // R2: change after the latch point
        tick(2);
        chk("R3", 1'b0, 1'b0);
        for (int e = 1; e <= n_edges; e++) begin
            if (e < LEAD) begin
                eo = 1'b0; es = 1'b0; tg = "R3";
            end else if (e == LEAD) begin
                eo = 1'b1; es = 1'b0; tg = "R3";
            end else if (e <= LEAD + DW) begin
                eo = 1'b1; es = 1'((u >> (DW - 1 - (e - LEAD - 1))) & 1); tg = dtag;
            end else begin
                eo = 1'b1; es = 1'b0; tg = "R5";
            end
            sclk = 1'b0;
            tick(4);
            chk(tg, eo, es);
            sclk = 1'b1;
            tick(4);
            chk("R4", eo, es);   // rising edge leaves outputs alone
        end
        cs_n = 1'b1;
        tick(4);
        chk(endtag, 1'b0, 1'b0);
        tick(2);
    endtask

    initial begin
        tick(3);
        chk("R9", 1'b0, 1'b0);
        rst_n = 1'b1;
        tick(4);
        chk("R9", 1'b0, 1'b0);

        // serial clock toggling while deselected
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b0; tick(4); chk("R1", 1'b0, 1'b0);
            sclk = 1'b1; tick(4); chk("R1", 1'b0, 1'b0);
        end

        // dedicated latch test with a value whose complement differs in every bit
        run_frame(90, FULL, "R2", "R1");

        // abort in mid-data, then a full frame must restart from the lead-in
        run_frame(85, LEAD + 3, "R4", "R8");
        run_frame(-37, FULL, "R8", "R1");

        // exhaustive sweep of the input space
        for (int v = -(1 << (IW-1)); v < (1 << (IW-1)); v++) begin
            string dt;
            if (v > (1 << (DW-1)) - 1)   dt = "R6";
            else if (v < -(1 << (DW-1))) dt = "R7";
            else                         dt = "R4";
            run_frame(v, FULL + (((v & 1) != 0) ? 2 : 0), dt, "R1");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule